// File: doc/BRIEF.md
# Row-Streaming Two-Dimensional Cluster Builder

This block joins the horizontal runs of a zero-suppressed pixel frame into two-dimensional clusters while the frame streams past. Each row arrives as a sequence of runs. A run is a starting column and a length, and the runs inside one row are already maximal. The block therefore only has to resolve connectivity between neighbouring rows. A small table keeps the clusters that are still open, together with the pixels each one gained in the previous row. Every incoming run is tested against those pixels. A run that touches an open cluster joins it. A run that touches two or more open clusters fuses them into one entry. A run that touches nothing claims a free entry.

When a row ends, every open cluster that gained no pixel in that row is finished. A finished cluster leaves through a valid/ready output as three items: the absolute row of its top edge, its leftmost column, and a square bitmap. A frame marker finishes everything that is still open. While finished clusters wait to drain, the input is held off. A downstream shape coder consumes the output.

Top module: `rc_cluster_builder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `drop_flag` is 0.
- R2: `in_kind` 0 is a run covering columns `in_col` to `in_col+in_len-1`. `in_kind` 1 ends the current row. `in_kind` 2 ends the frame. Row numbering starts at 0 and rises by one at each row end. A run that touches no open cluster starts a new cluster in the lowest-numbered free entry.
- R3: Adjacency is 8-connected. A run joins a cluster when one of the run's columns is within one column of a pixel that the cluster holds in the previous row. This includes diagonal contact. A column gap of two or more does not connect.
- R4: At a row end, an open cluster that gained no pixel in that row is finished and emitted. A cluster that gained at least one pixel stays open.
- R5: A run that touches two or more open clusters merges them into one cluster. The merged cluster is emitted once.
- R6: Each emitted cluster has three fields. `out_row` is its top row. `out_col` is its leftmost column. `out_map` bit `r*WIN+c` is set when pixel (`out_row+r`, `out_col+c`) belongs to the cluster. Row 0 and column 0 of the bitmap are never empty.
- R7: `out_ovf` is 1 when the cluster spans more than `WIN` rows or more than `WIN` columns. When `out_ovf` is 1, `out_map` is not defined. A cluster of exactly `WIN` by `WIN` pixels has `out_ovf` at 0.
- R8: A frame end finishes every open cluster. These clusters are emitted in ascending entry order, and the next row is numbered 0 again.
- R9: A run that touches no open cluster while all `N` entries are in use is discarded and produces no cluster. `drop_flag` is then set and stays at 1 until reset.
- R10: While `out_valid` is 1 and `out_ready` is 0, all output fields hold steady. `in_ready` stays at 0 while any finished cluster is still waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Input item accepted on this edge when valid |
| in_kind | input | 2 | 0 run, 1 row end, 2 frame end |
| in_col | input | $clog2(COLS) | First column of a run |
| in_len | input | $clog2(COLS)+1 | Number of pixels in a run (at least 1) |
| out_valid | output | 1 | Finished cluster present |
| out_ready | input | 1 | Consumer takes the cluster |
| out_row | output | ROW_W | Top row of the cluster |
| out_col | output | $clog2(COLS) | Leftmost column of the cluster |
| out_map | output | WIN*WIN | Pixel bitmap, bit r*WIN+c |
| out_ovf | output | 1 | Cluster larger than the bitmap window |
| drop_flag | output | 1 | Sticky: a run was lost because the table was full |

## Verification
The bench builds the block with `N=4`, `WIN=3`, `COLS=16` and `ROW_W=6`. With only four table entries, a full table and a discarded run take only five runs in one row. A 3-pixel window makes overflow in height and in width cheap to provoke. It also makes an exact 3-by-3 cluster, which must not overflow, a short pattern. The narrow row keeps every expected bitmap small enough to work out by hand.

// File: rtl/rc_pkg.sv
package rc_pkg;
   typedef enum logic [1:0] {
      RC_RUN       = 2'd0,
      RC_ROW_END   = 2'd1,
      RC_FRAME_END = 2'd2,
      RC_NOP       = 2'd3
   } rc_kind_e;
endpackage

// File: rtl/rc_lowest.sv
module rc_lowest #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IW'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rc_run_mask.sv
module rc_run_mask #(
   parameter int COLS  = 32,
   parameter int COL_W = $clog2(COLS),
   parameter int LEN_W = $clog2(COLS) + 1
) (
   input  logic [COL_W-1:0] col,
   input  logic [LEN_W-1:0] len,
   output logic [COLS-1:0]  run,
   output logic [COLS-1:0]  halo
);
   always_comb begin
      for (int c = 0; c < COLS; c++)
         run[c] = (c >= int'(col)) && (c < int'(col) + int'(len));
   end

   // widen by one column each side: diagonal contact counts
   assign halo = run | (run << 1) | (run >> 1);
endmodule

// File: rtl/rc_window.sv
module rc_window #(
   parameter int COLS   = 32,
   parameter int WIN    = 5,
   parameter int COL_W  = $clog2(COLS),
   parameter int SLOT_W = $clog2(WIN)
) (
   input  logic [WIN-1:0][COLS-1:0] rows,
   input  logic [SLOT_W-1:0]        top_slot,
   output logic [WIN*WIN-1:0]       map,
   output logic [COL_W-1:0]         min_col,
   output logic                     too_wide
);
   logic [COLS-1:0] ormask;
   logic [COLS-1:0] shifted;
   logic [COLS-1:0] line;
   int              slot;

   always_comb begin
      ormask = '0;
      for (int r = 0; r < WIN; r++) ormask |= rows[r];
      min_col = '0;
      for (int c = COLS - 1; c >= 0; c--)
         if (ormask[c]) min_col = COL_W'(c);
      shifted  = ormask >> min_col;
      too_wide = |(shifted >> WIN);
      map  = '0;
      line = '0;
      slot = 0;
      // unroll the ring so that the cluster's top row lands in map row 0
      for (int i = 0; i < WIN; i++) begin
         slot = (int'(top_slot) + i) % WIN;
         line = rows[slot] >> min_col;
         for (int c = 0; c < WIN; c++) map[i*WIN + c] = line[c];
      end
   end
endmodule

// File: rtl/rc_cluster_builder.sv
module rc_cluster_builder #(
   parameter int COLS  = 32,
   parameter int WIN   = 5,
   parameter int N     = 16,
   parameter int ROW_W = 10,
   localparam int COL_W  = $clog2(COLS),
   localparam int LEN_W  = $clog2(COLS) + 1,
   localparam int SLOT_W = $clog2(WIN),
   localparam int IW     = $clog2(N),
   localparam int MAP_W  = WIN * WIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [1:0]       in_kind,
   input  logic [COL_W-1:0] in_col,
   input  logic [LEN_W-1:0] in_len,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [ROW_W-1:0] out_row,
   output logic [COL_W-1:0] out_col,
   output logic [MAP_W-1:0] out_map,
   output logic             out_ovf,
   output logic             drop_flag
);
   import rc_pkg::*;

   if (WIN < 2) begin : g_bad_win
      $error("WIN must be 2 or more");
   end
   if (N < 2) begin : g_bad_n
      $error("N must be 2 or more");
   end
   if (COLS < WIN) begin : g_bad_cols
      $error("COLS must not be below WIN");
   end
   if (ROW_W < SLOT_W + 1) begin : g_bad_row
      $error("ROW_W too narrow for WIN");
   end

   // table state
   logic [N-1:0]              open_q, ext_q, pend_q, ovf_q;
   logic [COLS-1:0]           prev_q  [N];
   logic [COLS-1:0]           cur_q   [N];
   logic [WIN-1:0][COLS-1:0]  rows_q  [N];
   logic [ROW_W-1:0]          top_q   [N];
   logic [SLOT_W-1:0]         tslot_q [N];
   logic [ROW_W-1:0]          row_q;
   logic [SLOT_W-1:0]         slot_q;
   logic                      drop_q;

   rc_kind_e        kind;
   logic            acc;
   logic [COLS-1:0] run_m, halo_m;
   logic [N-1:0]    touch;
   logic [IW-1:0]   tgt, free_idx, sel, wr_idx;
   logic            hit, free_any, any_pend;

   assign kind = rc_kind_e'(in_kind);
   assign acc  = in_valid && in_ready;

   rc_run_mask #(.COLS(COLS), .COL_W(COL_W), .LEN_W(LEN_W)) u_mask (
      .col(in_col), .len(in_len), .run(run_m), .halo(halo_m)
   );

   for (genvar e = 0; e < N; e++) begin : g_touch
      assign touch[e] = open_q[e] & (|(halo_m & prev_q[e]));
   end

   rc_lowest #(.N(N), .IW(IW)) u_tgt  (.req(touch),   .idx(tgt),      .any(hit));
   rc_lowest #(.N(N), .IW(IW)) u_free (.req(~open_q), .idx(free_idx), .any(free_any));
   rc_lowest #(.N(N), .IW(IW)) u_pend (.req(pend_q),  .idx(sel),      .any(any_pend));

   assign wr_idx = hit ? tgt : free_idx;

   // union of the incoming run and every cluster it touches
   logic [COLS-1:0]          m_cur, m_prev;
   logic [WIN-1:0][COLS-1:0] m_rows;
   logic [ROW_W-1:0]         m_top, m_span;
   logic [SLOT_W-1:0]        m_slot;
   logic                     m_ovf, m_tall;

   always_comb begin
      m_cur  = run_m;
      m_prev = '0;
      m_rows = '0;
      m_ovf  = 1'b0;
      m_top  = row_q;
      m_slot = slot_q;
      for (int e = 0; e < N; e++) begin
         if (touch[e]) begin
            m_cur  |= cur_q[e];
            m_prev |= prev_q[e];
            m_rows |= rows_q[e];
            m_ovf  |= ovf_q[e];
            if (top_q[e] < m_top) begin
               m_top  = top_q[e];
               m_slot = tslot_q[e];
            end
         end
      end
      m_rows[slot_q] = m_rows[slot_q] | run_m;
      m_span = row_q - m_top;
      m_tall = m_span >= ROW_W'(WIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= '0;
         ext_q  <= '0;
         pend_q <= '0;
         ovf_q  <= '0;
         row_q  <= '0;
         slot_q <= '0;
         drop_q <= 1'b0;
         for (int e = 0; e < N; e++) begin
            prev_q[e]  <= '0;
            cur_q[e]   <= '0;
            rows_q[e]  <= '0;
            top_q[e]   <= '0;
            tslot_q[e] <= '0;
         end
      end else begin
         if (any_pend && out_ready) begin
            open_q[sel] <= 1'b0;
            pend_q[sel] <= 1'b0;
         end
         if (acc) begin
            case (kind)
               RC_RUN: begin
                  if (hit || free_any) begin
                     open_q[wr_idx]  <= 1'b1;
                     ext_q[wr_idx]   <= 1'b1;
                     cur_q[wr_idx]   <= m_cur;
                     prev_q[wr_idx]  <= m_prev;
                     rows_q[wr_idx]  <= m_rows;
                     top_q[wr_idx]   <= m_top;
                     tslot_q[wr_idx] <= m_slot;
                     ovf_q[wr_idx]   <= m_ovf | m_tall;
                     for (int e = 0; e < N; e++) begin
                        if (touch[e] && (IW'(e) != wr_idx)) begin
                           open_q[e] <= 1'b0;
                           ext_q[e]  <= 1'b0;
                        end
                     end
                  end else begin
                     drop_q <= 1'b1;
                  end
               end
               RC_ROW_END: begin
                  for (int e = 0; e < N; e++) begin
                     if (open_q[e]) begin
                        if (ext_q[e]) begin
                           prev_q[e] <= cur_q[e];
                           cur_q[e]  <= '0;
                           ext_q[e]  <= 1'b0;
                        end else begin
                           pend_q[e] <= 1'b1;
                        end
                     end
                  end
                  row_q  <= row_q + 1'b1;
                  slot_q <= (slot_q == SLOT_W'(WIN - 1)) ? '0 : slot_q + 1'b1;
               end
               RC_FRAME_END: begin
                  for (int e = 0; e < N; e++) begin
                     if (open_q[e]) begin
                        pend_q[e] <= 1'b1;
                        ext_q[e]  <= 1'b0;
                     end
                  end
                  row_q  <= '0;
                  slot_q <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   logic too_wide;

   rc_window #(.COLS(COLS), .WIN(WIN), .COL_W(COL_W), .SLOT_W(SLOT_W)) u_win (
      .rows(rows_q[sel]), .top_slot(tslot_q[sel]),
      .map(out_map), .min_col(out_col), .too_wide(too_wide)
   );

   assign out_valid = any_pend;
   assign in_ready  = ~any_pend;
   assign out_row   = top_q[sel];
   assign out_ovf   = ovf_q[sel] | too_wide;
   assign drop_flag = drop_q;
endmodule

// File: rtl/rc_cluster_chk.sv
module rc_cluster_chk #(
   parameter int N     = 16,
   parameter int WIN   = 5,
   parameter int COL_W = 5,
   parameter int ROW_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [1:0]         in_kind,
   input logic               out_valid,
   input logic               out_ready,
   input logic [ROW_W-1:0]   out_row,
   input logic [COL_W-1:0]   out_col,
   input logic [WIN*WIN-1:0] out_map,
   input logic               out_ovf,
   input logic               drop_flag,
   input logic [N-1:0]       open_vec,
   input logic [N-1:0]       touch_vec
);
   logic col0_any;
   always_comb begin
      col0_any = 1'b0;
      for (int r = 0; r < WIN; r++) col0_any |= out_map[r*WIN];
   end

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_col)
                                  && $stable(out_map) && $stable(out_ovf));

   // R9
   drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_flag |=> drop_flag);

   // R9
   drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_kind == 2'd0 && (&open_vec) && touch_vec == '0 |=> drop_flag);

   // R8
   frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_kind == 2'd2 && (|open_vec) |=> out_valid && !in_ready);

   // R6
   top_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ovf |-> |out_map[WIN-1:0]);

   // R6
   left_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ovf |-> col0_any);
endmodule

bind rc_cluster_builder rc_cluster_chk #(
   .N(N), .WIN(WIN), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_kind(in_kind), .out_valid(out_valid), .out_ready(out_ready),
   .out_row(out_row), .out_col(out_col), .out_map(out_map), .out_ovf(out_ovf),
   .drop_flag(drop_flag), .open_vec(open_q), .touch_vec(touch)
);

// File: tb/tb_rc_cluster_builder.sv
`timescale 1ns/1ps
module tb_rc_cluster_builder;
   localparam int COLS  = 16;
   localparam int WIN   = 3;
   localparam int N     = 4;
   localparam int ROW_W = 6;
   localparam int COL_W = 4;
   localparam int LEN_W = 5;
   localparam int MAP_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [1:0]       in_kind = 2'd0;
   logic [COL_W-1:0] in_col = '0;
   logic [LEN_W-1:0] in_len = '0;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic [ROW_W-1:0] out_row;
   logic [COL_W-1:0] out_col;
   logic [MAP_W-1:0] out_map;
   logic             out_ovf;
   logic             drop_flag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rc_cluster_builder #(.COLS(COLS), .WIN(WIN), .N(N), .ROW_W(ROW_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_col(in_col), .in_len(in_len),
      .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
      .out_col(out_col), .out_map(out_map), .out_ovf(out_ovf), .drop_flag(drop_flag)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(int k, int c, int l);
      @(negedge clk);
      in_valid = 1'b1;
      in_kind  = 2'(k);
      in_col   = COL_W'(c);
      in_len   = LEN_W'(l);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run(int c, int l);   send(0, c, l); endtask
   task automatic row_end();           send(1, 0, 0); endtask
   task automatic frame_end();         send(2, 0, 0); endtask

   task automatic expect_cluster(string req, int row, int col, int map, int ovf, bit use_map);
      int n = 0;
      while (!out_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk(req, "out_valid", int'(out_valid), 1);
      chk(req, "out_row", int'(out_row), row);
      chk(req, "out_col", int'(out_col), col);
      chk(req, "out_ovf", int'(out_ovf), ovf);
      if (use_map) chk(req, "out_map", int'(out_map), map);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic expect_idle(string req);
      @(negedge clk);
      chk(req, "no cluster out_valid", int'(out_valid), 0);
   endtask

   task automatic t_reset();
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "in_ready", int'(in_ready), 1);
      chk("R1", "drop_flag", int'(drop_flag), 0);
   endtask

   // R2 R4 R6: two-row cluster stays open while extended, closes on an empty row
   task automatic t_vertical();
      run(4, 2);
      row_end();
      expect_idle("R4");
      run(5, 1);
      row_end();
      expect_idle("R4");
      row_end();
      expect_cluster("R4", 0, 4, 9'h013, 0, 1'b1);
      frame_end();
      expect_idle("R8");
   endtask

   // R3 R8: diagonal contact joins; two clusters leave in entry order
   task automatic t_diag();
      run(2, 1);
      row_end();
      run(3, 1);
      run(6, 1);
      row_end();
      frame_end();
      expect_cluster("R3", 0, 2, 9'h011, 0, 1'b1);
      expect_cluster("R8", 1, 6, 9'h001, 0, 1'b1);
      expect_idle("R8");
   endtask

   // R3 R4: a two-column gap does not connect
   task automatic t_gap();
      run(2, 1);
      row_end();
      run(4, 1);
      row_end();
      expect_cluster("R3", 0, 2, 9'h001, 0, 1'b1);
      row_end();
      expect_cluster("R4", 1, 4, 9'h001, 0, 1'b1);
      frame_end();
      expect_idle("R4");
   endtask

   // R5: one run bridges two clusters
   task automatic t_merge();
      run(1, 1);
      run(3, 1);
      row_end();
      run(1, 3);
      row_end();
      frame_end();
      expect_cluster("R5", 0, 1, 9'h03D, 0, 1'b1);
      expect_idle("R5");
   endtask

   // R7: too wide and too tall
   task automatic t_overflow();
      run(0, 1);
      run(8, 4);
      row_end();
      run(0, 1);
      row_end();
      expect_cluster("R7", 0, 8, 0, 1, 1'b0);
      run(0, 1);
      row_end();
      run(0, 1);
      row_end();
      frame_end();
      expect_cluster("R7", 0, 0, 0, 1, 1'b0);
      expect_idle("R7");
   endtask

   // R6 R7 R8: exactly WIN x WIN fits; row numbering restarted at 0
   task automatic t_exact();
      run(10, 3);
      row_end();
      run(10, 3);
      row_end();
      run(10, 3);
      row_end();
      frame_end();
      expect_cluster("R6", 0, 10, 9'h1FF, 0, 1'b1);
   endtask

   // R10: output holds and input stalls while the consumer waits
   task automatic t_handshake();
      run(5, 1);
      row_end();
      row_end();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R10", "held out_valid", int'(out_valid), 1);
         chk("R10", "in_ready low", int'(in_ready), 0);
         chk("R10", "held out_col", int'(out_col), 5);
      end
      expect_cluster("R10", 0, 5, 9'h001, 0, 1'b1);
      frame_end();
   endtask

   // R9 R8: full table discards a fifth run
   task automatic t_full();
      run(0, 1);
      run(3, 1);
      run(6, 1);
      run(9, 1);
      chk("R9", "drop before full", int'(drop_flag), 0);
      run(12, 1);
      chk("R9", "drop set", int'(drop_flag), 1);
      row_end();
      frame_end();
      expect_cluster("R8", 0, 0, 9'h001, 0, 1'b1);
      expect_cluster("R8", 0, 3, 9'h001, 0, 1'b1);
      expect_cluster("R8", 0, 6, 9'h001, 0, 1'b1);
      expect_cluster("R8", 0, 9, 9'h001, 0, 1'b1);
      expect_idle("R9");
      chk("R9", "drop sticky", int'(drop_flag), 1);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_vertical();
      t_diag();
      t_gap();
      t_merge();
      t_overflow();
      t_exact();
      t_handshake();
      t_full();
      repeat (4) @(negedge clk);
      summary();
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule